// File: doc/BRIEF.md
# Pixel Buffer Descriptor Table

This block keeps a table of frame-buffer descriptors for video engines. Each descriptor gives a buffer's base address and width, both in 8-byte units, plus its height, a wrap mode, a tiling mode and a byte-swap mask. Software never writes an entry directly. It fills two 32-bit staging words over a simple register bus. It then writes a command word that holds an entry index and a flag. The flag either commits the staged pair into that entry or fetches that entry back into the staging words. The width field is split across the two staging words.

A separate lookup port serves a pixel client. The client presents an index, and one clock later it gets the descriptor already split into fields. The table sits in one inferred two-port memory. The bus side uses one port to write and fetch entries, and the lookup side reads through the other port.

Top module: `pixbuf_desc_table`

## Requirements
- R1: After synchronous reset, both staging words and the command register read as zero, and `bus_ack` is low.
- R2: Word 0 (byte offset 0x0) is staging-low and holds all 32 bits written to it. Word 1 (0x4) is staging-high: it keeps bits 29:0, ignores bits 31:30 on a write, and returns them as zero on a read.
- R3: A command write (word 2, offset 0x8) with bit 9 set commits {staging-high, staging-low} into the entry selected by bits 7:0. Bits 31:10 of the command word are ignored.
- R4: A command write with bit 8 set and bit 9 clear loads the selected entry into both staging words.
- R5: When bits 9 and 8 are both set, only the commit happens, and the staging words keep their contents.
- R6: The lookup fields change exactly one clock after `lk_idx` changes, never earlier.
- R7: If a lookup samples the same index in the cycle that the commit writes it, the lookup returns the old contents. The new contents appear one cycle later.
- R8: A bus access is acknowledged with a one-cycle `bus_ack` pulse. An access presented while a commit or fetch is still in progress is held off until that operation finishes, so its result reflects the finished operation. A read issued right behind a fetch command is acknowledged three cycles after it is presented.
- R9: The fields decode from the staged words as follows:
  - base = low[28:0]
  - width = {high[8:0], low[31:29]}
  - height = high[21:9]
  - wrap = high[23:22]
  - tiling = high[25:24]
  - swap mask = high[29:26]

  Entries 0 and 255 are distinct, and every field carries any value, including wrap 0/1/2, tiling 0/1/2 and swap masks 0x1/0x3/0x7/0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| lk_idx | input | IDX_W | Lookup entry index |
| lk_base | output | 29 | Buffer base address in 8-byte units |
| lk_width | output | 12 | Buffer width in 8-byte units |
| lk_height | output | 13 | Buffer height in lines |
| lk_wrap | output | 2 | Wrap mode: 0 none, 1 X, 2 Y |
| lk_blkmode | output | 2 | Tiling: 0 linear, 1 32x32, 2 64x64 |
| lk_endian | output | 4 | Byte-swap mask |

## Verification
The bench builds the table with its default of 256 entries. This puts the top index 255 and index 0 in reach of a single 8-bit command field, so the test shows that the two ends of the table never alias. At that depth the full command index width is exercised, and so is the masking of command bits 31:10. The same build also reaches the port collision case, where a commit and a lookup hit one entry in the same cycle, and the hold-off of a read issued back-to-back behind a fetch.

// File: rtl/pixbuf_desc_pkg.sv
package pixbuf_desc_pkg;
  localparam int WORD_W     = 32;
  localparam int BASE_W     = 29;
  localparam int WIDTH_W    = 12;
  localparam int WIDTH_LO_W = WORD_W - BASE_W;
  localparam int WIDTH_HI_W = WIDTH_W - WIDTH_LO_W;
  localparam int HEIGHT_W   = 13;
  localparam int WRAP_W     = 2;
  localparam int BLK_W      = 2;
  localparam int ENDIAN_W   = 4;

  localparam int HI_HEIGHT_POS = WIDTH_HI_W;
  localparam int HI_WRAP_POS   = HI_HEIGHT_POS + HEIGHT_W;
  localparam int HI_BLK_POS    = HI_WRAP_POS + WRAP_W;
  localparam int HI_ENDIAN_POS = HI_BLK_POS + BLK_W;
  localparam int HI_USED_W     = HI_ENDIAN_POS + ENDIAN_W;
  localparam int ENTRY_W       = WORD_W + HI_USED_W;

  localparam int CMD_COMMIT_BIT = 9;
  localparam int CMD_FETCH_BIT  = 8;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_COMMIT,
    OP_FETCH,
    OP_LOAD
  } op_state_e;

  typedef struct packed {
    logic [BASE_W-1:0]   base;
    logic [WIDTH_W-1:0]  width;
    logic [HEIGHT_W-1:0] height;
    logic [WRAP_W-1:0]   wrap;
    logic [BLK_W-1:0]    blkmode;
    logic [ENDIAN_W-1:0] endian;
  } desc_t;
endpackage

// File: rtl/pixbuf_desc_ram.sv
module pixbuf_desc_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 62,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_q,
  input  logic [AW-1:0]    b_addr,
  output logic [WIDTH-1:0] b_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Port A: bus-side write / fetch, read-before-write
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_q <= mem[a_addr];
    end
  end

  // Port B: lookup, always enabled; returns old data on a same-cycle write
  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/pixbuf_desc_unpack.sv
module pixbuf_desc_unpack
  import pixbuf_desc_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output desc_t              fields
);
  logic [WORD_W-1:0]    lo_w;
  logic [HI_USED_W-1:0] hi_w;

  assign lo_w = entry[WORD_W-1:0];
  assign hi_w = entry[ENTRY_W-1:WORD_W];

  always_comb begin
    fields.base    = lo_w[BASE_W-1:0];
    fields.width   = {hi_w[WIDTH_HI_W-1:0], lo_w[WORD_W-1:BASE_W]};
    fields.height  = hi_w[HI_HEIGHT_POS +: HEIGHT_W];
    fields.wrap    = hi_w[HI_WRAP_POS +: WRAP_W];
    fields.blkmode = hi_w[HI_BLK_POS +: BLK_W];
    fields.endian  = hi_w[HI_ENDIAN_POS +: ENDIAN_W];
  end
endmodule

// File: rtl/pixbuf_desc_regif.sv
module pixbuf_desc_regif
  import pixbuf_desc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_ack,
  output logic               ram_en,
  output logic               ram_we,
  output logic [IDX_W-1:0]   ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  input  logic [ENTRY_W-1:0] ram_q,
  output logic               busy
);
  logic [WORD_W-1:0]    stage_lo;
  logic [HI_USED_W-1:0] stage_hi;
  logic [IDX_W-1:0]     cmd_idx;
  op_state_e            state;
  word_sel_e            sel;
  logic                 accept;
  logic [WORD_W-1:0]    rd_mux;
  logic                 unused_bits;

  assign sel         = word_sel_e'(bus_addr[3:2]);
  assign busy        = (state != OP_IDLE);
  assign accept      = bus_req && !bus_ack && !busy;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_comb begin
    case (sel)
      SEL_LOW:  rd_mux = stage_lo;
      SEL_HIGH: rd_mux = WORD_W'(stage_hi);
      SEL_CMD:  rd_mux = WORD_W'(cmd_idx);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo  <= '0;
      stage_hi  <= '0;
      cmd_idx   <= '0;
      state     <= OP_IDLE;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= accept;
      case (state)
        OP_COMMIT: state <= OP_IDLE;
        OP_FETCH:  state <= OP_LOAD;
        OP_LOAD: begin
          stage_lo <= ram_q[WORD_W-1:0];
          stage_hi <= ram_q[ENTRY_W-1:WORD_W];
          state    <= OP_IDLE;
        end
        default: begin
          if (accept) begin
            if (bus_we) begin
              case (sel)
                SEL_LOW:  stage_lo <= bus_wdata;
                SEL_HIGH: stage_hi <= bus_wdata[HI_USED_W-1:0];
                SEL_CMD: begin
                  cmd_idx <= bus_wdata[IDX_W-1:0];
                  if (bus_wdata[CMD_COMMIT_BIT])      state <= OP_COMMIT;
                  else if (bus_wdata[CMD_FETCH_BIT])  state <= OP_FETCH;
                end
                default: ;
              endcase
            end else begin
              bus_rdata <= rd_mux;
            end
          end
        end
      endcase
    end
  end

  assign ram_en    = (state == OP_COMMIT) || (state == OP_FETCH);
  assign ram_we    = (state == OP_COMMIT);
  assign ram_addr  = cmd_idx;
  assign ram_wdata = {stage_hi, stage_lo};
endmodule

// File: rtl/pixbuf_desc_table.sv
module pixbuf_desc_table
  import pixbuf_desc_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [28:0]       lk_base,
  output logic [11:0]       lk_width,
  output logic [12:0]       lk_height,
  output logic [1:0]        lk_wrap,
  output logic [1:0]        lk_blkmode,
  output logic [3:0]        lk_endian
);
  logic               ram_a_en;
  logic               ram_a_we;
  logic [IDX_W-1:0]   ram_a_addr;
  logic [ENTRY_W-1:0] ram_a_wdata;
  logic [ENTRY_W-1:0] ram_a_q;
  logic [ENTRY_W-1:0] ram_b_q;
  logic               op_busy;
  desc_t              lk_fields;

  pixbuf_desc_regif #(.IDX_W(IDX_W)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .ram_en    (ram_a_en),
    .ram_we    (ram_a_we),
    .ram_addr  (ram_a_addr),
    .ram_wdata (ram_a_wdata),
    .ram_q     (ram_a_q),
    .busy      (op_busy)
  );

  pixbuf_desc_ram #(.DEPTH(ENTRIES), .WIDTH(ENTRY_W)) u_ram (
    .clk     (clk),
    .a_en    (ram_a_en),
    .a_we    (ram_a_we),
    .a_addr  (ram_a_addr),
    .a_wdata (ram_a_wdata),
    .a_q     (ram_a_q),
    .b_addr  (lk_idx),
    .b_q     (ram_b_q)
  );

  pixbuf_desc_unpack u_unpack (
    .entry  (ram_b_q),
    .fields (lk_fields)
  );

  assign lk_base    = lk_fields.base;
  assign lk_width   = lk_fields.width;
  assign lk_height  = lk_fields.height;
  assign lk_wrap    = lk_fields.wrap;
  assign lk_blkmode = lk_fields.blkmode;
  assign lk_endian  = lk_fields.endian;
endmodule

// File: rtl/pixbuf_desc_table_chk.sv
module pixbuf_desc_table_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             bus_ack,
  input logic             busy,
  input logic             ram_en,
  input logic             ram_we,
  input logic [IDX_W-1:0] lk_idx,
  input logic [28:0]      lk_base
);
  logic cmd_acc;
  assign cmd_acc = bus_req && !bus_ack && !busy && bus_we && (bus_addr[3:2] == 2'd2);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!bus_ack && !busy));

  assert_high_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && !bus_we && bus_addr[3:2] == 2'd1) |-> (bus_rdata[31:30] == 2'b00));

  assert_commit_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_acc && bus_wdata[9]) |=> ram_we);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_acc && bus_wdata[9] && bus_wdata[8]) |=> !(ram_en && !ram_we));

  assert_lookup_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($stable(lk_idx) && !$past(ram_we)) |=> $stable(lk_base));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_ack_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> !$past(busy));
endmodule

bind pixbuf_desc_table pixbuf_desc_table_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ack   (bus_ack),
  .busy      (op_busy),
  .ram_en    (ram_a_en),
  .ram_we    (ram_a_we),
  .lk_idx    (lk_idx),
  .lk_base   (lk_base)
);

// File: tb/pixbuf_desc_table_test.sv
module pixbuf_desc_table_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  lk_idx = '0;
  logic [28:0] lk_base;
  logic [11:0] lk_width;
  logic [12:0] lk_height;
  logic [1:0]  lk_wrap;
  logic [1:0]  lk_blkmode;
  logic [3:0]  lk_endian;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  pixbuf_desc_table uut (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .lk_idx(lk_idx), .lk_base(lk_base), .lk_width(lk_width),
    .lk_height(lk_height), .lk_wrap(lk_wrap), .lk_blkmode(lk_blkmode),
    .lk_endian(lk_endian)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [3:0] addr,
                        input logic [31:0] wd, output logic [31:0] rdv);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    do @(negedge clk); while (!bus_ack);
    rdv = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic logic [31:0] pack_lo(input logic [28:0] b, input logic [11:0] w);
    return {w[2:0], b};
  endfunction

  function automatic logic [31:0] pack_hi(input logic [11:0] w, input logic [12:0] h,
      input logic [1:0] wr, input logic [1:0] bm, input logic [3:0] en);
    return {2'b00, en, bm, wr, h, w[11:3]};
  endfunction

  task automatic stage_and_commit(input logic [7:0] idx, input logic [28:0] b,
      input logic [11:0] w, input logic [12:0] h, input logic [1:0] wr,
      input logic [1:0] bm, input logic [3:0] en);
    logic [31:0] d;
    bus_op(1'b1, 4'h0, pack_lo(b, w), d);
    bus_op(1'b1, 4'h4, pack_hi(w, h, wr, bm, en), d);
    bus_op(1'b1, 4'h8, 32'h0000_0200 | 32'(idx), d);
  endtask

  task automatic lookup_chk(input string req, input logic [7:0] idx, input logic [28:0] b,
      input logic [11:0] w, input logic [12:0] h, input logic [1:0] wr,
      input logic [1:0] bm, input logic [3:0] en);
    @(negedge clk);
    lk_idx = idx;
    @(negedge clk);
    chk(req, 64'(lk_base), 64'(b));
    chk(req, 64'(lk_width), 64'(w));
    chk(req, 64'(lk_height), 64'(h));
    chk(req, 64'({lk_wrap, lk_blkmode, lk_endian}), 64'({wr, bm, en}));
  endtask

  task automatic t_reset;
    chk("R1 ack low", 64'(bus_ack), 64'd0);
    bus_op(1'b0, 4'h0, 32'd0, rd); chk("R1 low word", 64'(rd), 64'd0);
    bus_op(1'b0, 4'h4, 32'd0, rd); chk("R1 high word", 64'(rd), 64'd0);
    bus_op(1'b0, 4'h8, 32'd0, rd); chk("R1 cmd word", 64'(rd), 64'd0);
  endtask

  task automatic t_staging;
    bus_op(1'b1, 4'h0, 32'hDEAD_BEEF, rd);
    bus_op(1'b0, 4'h0, 32'd0, rd); chk("R2 low holds 32 bits", 64'(rd), 64'hDEAD_BEEF);
    bus_op(1'b1, 4'h4, 32'hFFFF_FFFF, rd);
    bus_op(1'b0, 4'h4, 32'd0, rd); chk("R2 high bits 31:30 zero", 64'(rd), 64'h3FFF_FFFF);
  endtask

  task automatic t_commit;
    // R9 ends of the table and field ranges; R3 plain commit
    stage_and_commit(8'd0, 29'h1ABC_DEF0, 12'hFFF, 13'h1FFF, 2'd2, 2'd1, 4'hF);
    stage_and_commit(8'd255, 29'h0000_0123, 12'h801, 13'h0001, 2'd1, 2'd2, 4'h3);
    lookup_chk("R3 entry 255", 8'd255, 29'h0000_0123, 12'h801, 13'h0001, 2'd1, 2'd2, 4'h3);
    lookup_chk("R9 entry 0 untouched", 8'd0, 29'h1ABC_DEF0, 12'hFFF, 13'h1FFF, 2'd2, 2'd1, 4'hF);
    // R3 command upper bits ignored
    bus_op(1'b1, 4'h0, pack_lo(29'h0055_5555, 12'h007), rd);
    bus_op(1'b1, 4'h4, pack_hi(12'h007, 13'h0AAA, 2'd0, 2'd0, 4'h7), rd);
    bus_op(1'b1, 4'h8, 32'hFFFF_FC00 | 32'h200 | 32'd17, rd);
    lookup_chk("R3 upper cmd bits ignored", 8'd17, 29'h0055_5555, 12'h007, 13'h0AAA, 2'd0, 2'd0, 4'h7);
    bus_op(1'b0, 4'h8, 32'd0, rd); chk("R3 cmd index", 64'(rd), 64'd17);
    stage_and_commit(8'd40, 29'h0, 12'h008, 13'h0100, 2'd0, 2'd0, 4'h1);
    lookup_chk("R9 swap16 linear", 8'd40, 29'h0, 12'h008, 13'h0100, 2'd0, 2'd0, 4'h1);
  endtask

  task automatic t_fetch;
    int n;
    bus_op(1'b1, 4'h0, 32'h1234_5678, rd);
    bus_op(1'b1, 4'h4, 32'h0BAD_F00D, rd);
    // fetch entry 255, then a read of the low word queued straight behind it
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0000_01FF;
    do @(negedge clk); while (!bus_ack);
    bus_we = 1'b0; bus_addr = 4'h0;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ack && n < 20);
    rd = bus_rdata;
    bus_req = 1'b0;
    chk("R8 hold-off latency", 64'(n), 64'd3);
    chk("R4 fetched low", 64'(rd), 64'(pack_lo(29'h0000_0123, 12'h801)));
    bus_op(1'b0, 4'h4, 32'd0, rd);
    chk("R4 fetched high", 64'(rd), 64'(pack_hi(12'h801, 13'h0001, 2'd1, 2'd2, 4'h3)));
    n = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'h4;
    do begin @(negedge clk); n++; end while (!bus_ack && n < 20);
    bus_req = 1'b0;
    chk("R8 idle read latency", 64'(n), 64'd1);
  endtask

  task automatic t_dual;
    stage_and_commit(8'd9, 29'h0000_0AAA, 12'h010, 13'h0020, 2'd1, 2'd1, 4'h1);
    bus_op(1'b1, 4'h0, pack_lo(29'h0BBB_0000, 12'h0F0), rd);
    bus_op(1'b1, 4'h4, pack_hi(12'h0F0, 13'h0444, 2'd2, 2'd2, 4'h7), rd);
    bus_op(1'b1, 4'h8, 32'h0000_0309, rd);
    bus_op(1'b0, 4'h0, 32'd0, rd);
    chk("R5 staging kept", 64'(rd), 64'(pack_lo(29'h0BBB_0000, 12'h0F0)));
    lookup_chk("R5 write taken", 8'd9, 29'h0BBB_0000, 12'h0F0, 13'h0444, 2'd2, 2'd2, 4'h7);
  endtask

  task automatic t_latency;
    @(negedge clk); lk_idx = 8'd0;
    @(negedge clk);
    lk_idx = 8'd255;
    #1 chk("R6 no early change", 64'(lk_base), 64'h1ABC_DEF0);
    @(negedge clk);
    chk("R6 one-cycle update", 64'(lk_base), 64'h0000_0123);
  endtask

  task automatic t_collide;
    stage_and_commit(8'd5, 29'h0000_1111, 12'h001, 13'h0001, 2'd0, 2'd0, 4'h1);
    bus_op(1'b1, 4'h0, pack_lo(29'h0000_2222, 12'h001), rd);
    @(negedge clk); lk_idx = 8'd0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0000_0205;
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0;
    lk_idx = 8'd5;
    @(negedge clk);
    chk("R7 old contents on collision", 64'(lk_base), 64'h0000_1111);
    @(negedge clk);
    chk("R7 new contents next cycle", 64'(lk_base), 64'h0000_2222);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_staging();
    t_commit();
    t_fetch();
    t_dual();
    t_latency();
    t_collide();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule